// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Store Access Controller

This block sits on a small CPU register bus and gives software byte access to a 4096-byte nonvolatile data store. The store is a separate address space from program and working memory. The block holds the store model itself. Software loads a 12-bit byte address into two address registers and places a byte in the data register. It then triggers an access through the control register. A read places the addressed byte in the data register. A write puts the data register's byte into the store.

Every triggered access halts the CPU through a stall output for a fixed number of cycles: four for a read and two for a write. A write is then self-timed. A busy flag in the control register stays set for a parameterised number of cycles, and software polls that flag before it starts the next access. Writes are guarded against accidents. The write strobe has an effect only while an arming bit, set by an earlier bus write, is still alive. The arming bit clears itself a few cycles after it is set.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset all four registers read 0x00 and `cpuStall` is low.
- R2: The high address register (offset 1) keeps only bits 3:0. Its bits 7:4 always read zero, and writing ones to them changes nothing.
- R3: Writing 1 to control bit 0 (offset 3) starts a read. `cpuStall` is then high for exactly 4 cycles, and once it drops the data register holds the byte at the current 12-bit address.
- R4: An accepted write holds `cpuStall` high for exactly 2 cycles.
- R5: Writing 1 to control bit 2 arms writes. Bit 2 reads 1 for exactly 4 cycles and then clears itself. A write-strobe (bit 1) while unarmed causes no stall and no busy, and leaves the store unchanged.
- R6: Control bit 1 reads 1 for exactly WRITE_CYCLES (default 64) cycles, counted from the cycle after an accepted write strobe.
- R7: While busy, read and write triggers are ignored: no stall, no change to the data register, no change to the store, and the busy time is not extended.
- R8: The low address register (offset 0) and the data register (offset 2) read back the last byte written to them over the bus.
- R9: Each of the 4096 byte addresses, including 0x000 and 0xFFF, holds its own value independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe from the CPU bus |
| regAddr | input | 2 | Register offset: 0 addr low, 1 addr high, 2 data, 3 control |
| regWrData | input | 8 | Write data from the CPU bus |
| regRdData | output | 8 | Read data for the selected register (combinational) |
| cpuStall | output | 1 | Holds the CPU pipeline while high |

## Verification
Bytes are written to the two extreme addresses and to two mid-range addresses with differing high nibbles, then read back. This separates a true 12-bit decode from aliasing on either address register. Write strobes are sent while armed, after the arming window has just closed, and during a busy period. Triggers that are correctly ignored leave the stall low and the store unchanged, while a leaky guard shows up as a stall or as corrupted data. The stall and busy widths are counted cycle by cycle, so a read stall and a write stall that have been swapped or are off by one are told apart.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  localparam logic [1:0] REG_ADDR_LO = 2'd0;
  localparam logic [1:0] REG_ADDR_HI = 2'd1;
  localparam logic [1:0] REG_DATA    = 2'd2;
  localparam logic [1:0] REG_CTRL    = 2'd3;

  localparam int BIT_RD_TRIG = 0;
  localparam int BIT_WR_TRIG = 1;
  localparam int BIT_ARM     = 2;

  typedef struct packed {
    logic loadAddrLo;
    logic loadAddrHi;
    logic loadData;
    logic memRead;
    logic memWrite;
  } nvmStrobe_t;

endpackage

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int READ_STALL   = 4,
  parameter int WRITE_STALL  = 2,
  parameter int ARM_CYCLES   = 4,
  parameter int WRITE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output nvmStrobe_t strobes,
  output logic       cpuStall,
  output logic       writeBusy,
  output logic       armed
);

  localparam int STALL_MAX = (READ_STALL > WRITE_STALL) ? READ_STALL : WRITE_STALL;
  localparam int STALL_W   = $clog2(STALL_MAX + 1);
  localparam int ARM_W     = $clog2(ARM_CYCLES + 1);
  localparam int BUSY_W    = $clog2(WRITE_CYCLES + 1);

  logic [STALL_W-1:0] stallCnt;
  logic               stallIsRead;
  logic [ARM_W-1:0]   armCnt;
  logic [BUSY_W-1:0]  busyCnt;

  logic ctrlWr, idle, writeAccept, readAccept;

  always_comb begin
    ctrlWr      = regWrEn && (regAddr == REG_CTRL);
    idle        = (busyCnt == '0) && (stallCnt == '0);
    writeAccept = ctrlWr && regWrData[BIT_WR_TRIG] && (armCnt != '0) && idle;
    readAccept  = ctrlWr && regWrData[BIT_RD_TRIG] && !regWrData[BIT_WR_TRIG] && idle;

    strobes.loadAddrLo = regWrEn && (regAddr == REG_ADDR_LO);
    strobes.loadAddrHi = regWrEn && (regAddr == REG_ADDR_HI);
    strobes.loadData   = regWrEn && (regAddr == REG_DATA);
    strobes.memWrite   = writeAccept;
    strobes.memRead    = stallIsRead && (stallCnt == STALL_W'(1));

    cpuStall  = (stallCnt != '0);
    writeBusy = (busyCnt != '0);
    armed     = (armCnt != '0);
  end

  // stall timer: length picked by access kind
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt    <= '0;
      stallIsRead <= 1'b0;
    end else if (readAccept) begin
      stallCnt    <= STALL_W'(READ_STALL);
      stallIsRead <= 1'b1;
    end else if (writeAccept) begin
      stallCnt    <= STALL_W'(WRITE_STALL);
      stallIsRead <= 1'b0;
    end else if (stallCnt != '0) begin
      stallCnt <= stallCnt - STALL_W'(1);
      if (stallCnt == STALL_W'(1)) stallIsRead <= 1'b0;
    end
  end

  // arming window: self-clearing, consumed by an accepted write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armCnt <= '0;
    end else if (writeAccept) begin
      armCnt <= '0;
    end else if (ctrlWr && regWrData[BIT_ARM]) begin
      armCnt <= ARM_W'(ARM_CYCLES);
    end else if (armCnt != '0) begin
      armCnt <= armCnt - ARM_W'(1);
    end
  end

  // self-timed write duration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (writeAccept) begin
      busyCnt <= BUSY_W'(WRITE_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - BUSY_W'(1);
    end
  end

  AST_BUSY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeBusy) |-> $past(armed)); // R5

  AST_NO_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    writeBusy |=> !$rose(cpuStall)); // R7

  AST_READ_ENDS_STALL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memRead |=> !cpuStall); // R3

  AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(armed) && !strobes.memWrite) |=> armed); // R5

endmodule

// File: rtl/nvm_datapath.sv
module nvm_datapath
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvmStrobe_t        strobes,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              writeBusy,
  input  logic              armed,
  output logic [DATA_W-1:0] regRdData
);

  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobes.loadAddrLo) addrReg[DATA_W-1:0]      <= regWrData;
      if (strobes.loadAddrHi) addrReg[ADDR_W-1:DATA_W] <= regWrData[HI_W-1:0];
      if (strobes.memRead)       dataReg <= store[addrReg];
      else if (strobes.loadData) dataReg <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.memWrite) store[addrReg] <= dataReg;
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      REG_ADDR_LO: regRdData = addrReg[DATA_W-1:0];
      REG_ADDR_HI: regRdData = {{(DATA_W-HI_W){1'b0}}, addrReg[ADDR_W-1:DATA_W]};
      REG_DATA:    regRdData = dataReg;
      REG_CTRL: begin
        regRdData[BIT_WR_TRIG] = writeBusy;
        regRdData[BIT_ARM]     = armed;
      end
      default:     regRdData = '0;
    endcase
  end

  always_comb begin
    if (rstN && regAddr == REG_ADDR_HI)
      AST_RESERVED_ZERO: assert (regRdData[DATA_W-1:HI_W] == '0); // R2
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memRead |-> !strobes.memWrite); // R7

endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int READ_STALL   = 4,
  parameter int WRITE_STALL  = 2,
  parameter int ARM_CYCLES   = 4,
  parameter int WRITE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       cpuStall
);

  nvmStrobe_t strobes;
  logic       writeBusy;
  logic       armed;

  nvm_ctrl #(
    .READ_STALL  (READ_STALL),
    .WRITE_STALL (WRITE_STALL),
    .ARM_CYCLES  (ARM_CYCLES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobes  (strobes),
    .cpuStall (cpuStall),
    .writeBusy(writeBusy),
    .armed    (armed)
  );

  nvm_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(8)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .writeBusy(writeBusy),
    .armed    (armed),
    .regRdData(regRdData)
  );

endmodule

// File: tb/tb_nvm_access_ctrl.sv
module tb_nvm_access_ctrl;

  localparam int WRITE_CYCLES = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd3;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       cpuStall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  nvm_access_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cpuStall(cpuStall)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd3;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
    regAddr = 2'd3;
  endtask

  task automatic countStall(output int n);
    n = 0;
    while (cpuStall) begin n++; @(negedge clk); end
  endtask

  task automatic countBusy(output int n);
    logic [7:0] c;
    n = 0;
    busRead(2'd3, c);
    while (c[1]) begin n++; @(negedge clk); busRead(2'd3, c); end
  endtask

  task automatic setAddr(input logic [11:0] a);
    busWrite(2'd0, a[7:0]);
    busWrite(2'd1, {4'h0, a[11:8]});
  endtask

  task automatic writeByte(input logic [11:0] a, input logic [7:0] v, input bit measure);
    logic [7:0] c;
    int sn, bn;
    setAddr(a);
    busWrite(2'd2, v);
    busWrite(2'd3, 8'h04);
    busRead(2'd3, c);
    if (measure) check(c[2] == 1'b1, "R5 armed after set", c[2], 1);
    busWrite(2'd3, 8'h02);
    countStall(sn);
    if (measure) check(sn == 2, "R4 write stall", sn, 2);
    countBusy(bn);
    if (measure) check(bn == WRITE_CYCLES - 2, "R6 busy length", bn + 2, WRITE_CYCLES);
  endtask

  task automatic readByte(input logic [11:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    int sn;
    setAddr(a);
    busWrite(2'd3, 8'h01);
    countStall(sn);
    check(sn == 4, "R3 read stall", sn, 4);
    busRead(2'd2, d);
    check(d == exp, req, d, exp);
  endtask

  task automatic testReset();
    logic [7:0] d;
    for (int i = 0; i < 4; i++) begin
      busRead(2'(i), d);
      check(d == 8'h00, "R1 reset value", d, 0);
    end
    check(cpuStall == 1'b0, "R1 stall low", cpuStall, 0);
  endtask

  task automatic testRegisters();
    logic [7:0] d;
    busWrite(2'd1, 8'hFF);
    busRead(2'd1, d);
    check(d == 8'h0F, "R2 reserved bits", d, 8'h0F);
    busWrite(2'd0, 8'hA5);
    busRead(2'd0, d);
    check(d == 8'hA5, "R8 addr low", d, 8'hA5);
    busWrite(2'd2, 8'h3C);
    busRead(2'd2, d);
    check(d == 8'h3C, "R8 data reg", d, 8'h3C);
  endtask

  task automatic testStoreRoundTrip();
    writeByte(12'h000, 8'h11, 1'b1);
    writeByte(12'hFFF, 8'hEE, 1'b1);
    writeByte(12'h5A3, 8'h5A, 1'b1);
    writeByte(12'h123, 8'hC3, 1'b1);
    readByte(12'h000, 8'h11, "R9 addr 000");
    readByte(12'hFFF, 8'hEE, "R9 addr FFF");
    readByte(12'h5A3, 8'h5A, "R9 addr 5A3");
    readByte(12'h123, 8'hC3, "R9 addr 123");
  endtask

  task automatic testArmExpiry();
    logic [7:0] c;
    setAddr(12'h5A3);
    busWrite(2'd2, 8'h99);
    busWrite(2'd3, 8'h04);
    repeat (3) @(negedge clk);
    busRead(2'd3, c);
    check(c[2] == 1'b1, "R5 armed in 4th cycle", c[2], 1);
    @(negedge clk);
    busRead(2'd3, c);
    check(c[2] == 1'b0, "R5 arm self-clears", c[2], 0);
    busWrite(2'd3, 8'h02);
    check(cpuStall == 1'b0, "R5 unarmed no stall", cpuStall, 0);
    busRead(2'd3, c);
    check(c[1] == 1'b0, "R5 unarmed no busy", c[1], 0);
    readByte(12'h5A3, 8'h5A, "R5 store unchanged");
  endtask

  task automatic testBusyIgnore();
    logic [7:0] d;
    int bn;
    setAddr(12'h700);
    busWrite(2'd2, 8'h42);
    busWrite(2'd3, 8'h04);
    busWrite(2'd3, 8'h02);
    repeat (3) @(negedge clk);
    busWrite(2'd3, 8'h01);
    check(cpuStall == 1'b0, "R7 read ignored stall", cpuStall, 0);
    @(negedge clk);
    busRead(2'd2, d);
    check(d == 8'h42, "R7 data reg unchanged", d, 8'h42);
    setAddr(12'h123);
    busWrite(2'd2, 8'h77);
    busWrite(2'd3, 8'h04);
    busWrite(2'd3, 8'h02);
    check(cpuStall == 1'b0, "R7 write ignored stall", cpuStall, 0);
    countBusy(bn);
    check(bn < WRITE_CYCLES - 10, "R7 busy not extended", bn, WRITE_CYCLES - 10);
    readByte(12'h123, 8'hC3, "R7 store unchanged");
    readByte(12'h700, 8'h42, "R9 addr 700");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegisters();
    testStoreRoundTrip();
    testArmExpiry();
    testBusyIgnore();
    finishRun();
  end

endmodule